// File: doc/BRIEF.md
# ADC Register Bank with Synthetic Sample Source

This block is the register front end of an analog-to-digital converter peripheral. There is no real converter behind it. A step counter stands in for one, so firmware and system tests can run and get changing, plausible conversion results. The block answers 32-bit word accesses on a small valid/ready register bus whose address window is 256 bytes wide.

The bank holds the following registers:
- a status word
- two control words
- two sampling-time words
- three regular-sequence words
- one injected-sequence word
- high and low watchdog limits
- four injected channel offsets
- four injected data words
- the regular data word

Most of these registers are plain storage. A few have access side effects:
- Status bits can be cleared by a write but never set by one.
- Offsets keep only twelve bits.
- An injected data read returns the stored word minus that channel's offset.
- A read of the regular data word while conversion is enabled and software-started advances the synthetic sample by seven. The read then masks the sample to the selected resolution, optionally left-aligns it, and clears the start request.

Top module: `adcreg_bank`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero except the high watchdog limit at byte offset 0x24, which reads 0x00000FFF.
- R2: A write to status (offset 0x00) leaves status equal to its old value ANDed with write data bits 5:0. A status bit is never set by a write.
- R3: Reading control word 2 (offset 0x08) returns its stored bits 27:0, with bits 31:28 always zero.
- R4: A write to an injected offset (offsets 0x14, 0x18, 0x1C, 0x20 for channels 0 to 3) stores only write data bits 11:0. Bits 31:12 read back as zero.
- R5: Reading injected data channel n (offsets 0x3C + 4n) returns stored data n minus offset n, modulo 2^32.
- R6: A read of the data word (offset 0x4C) is a conversion read when control word 2 has both bit 0 (enable) and bit 30 (start) set. A conversion read stores (sample + 7) masked to the resolution, returns that sample, and clears bit 30. A second read with no new start therefore returns zero.
- R7: The resolution is control word 1 (offset 0x04) bits 25:24. Code 0 masks the sample with 0xFFF, 1 with 0x3FF, 2 with 0xFF and 3 with 0x3F. The stored sample never exceeds 12 bits.
- R8: When control word 2 bit 11 is set, a conversion read returns (sample << 1) AND 0xFFF0. When bit 11 is clear, it returns the masked sample itself.
- R9: A data-word read without both enable and start returns zero and leaves the stored sample unchanged.
- R10: Reads from undecoded offsets (0x50 to 0xFC) return zero. Writes to those offsets, and writes to the data word, have no effect.
- R11: bus_ready is always high. bus_rvalid pulses for exactly one cycle, in the cycle after each read handshake, and never follows a write.
- R12: Control word 1, both sampling-time words, the watchdog limits, the three sequence words (0x2C, 0x30, 0x34), the injected sequence word (0x38) and the injected data words keep the full 32-bit value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Access accepted (constant high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the window; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle read data strobe |

## Verification
The hardest conditions to reach are the wrap points of the synthetic sample at the narrower resolutions. Each step needs a fresh start request, and the sample is visible only through the same read that advances it. The stimulus runs forty start-and-read pairs at each of the 10-, 8- and 6-bit settings, with the counter carried across resolution changes. This drives the sample past 0x3F and 0xFF several times, and a zero-returning re-read follows every conversion to show that the start bit was cleared. Idle data reads with only one of enable and start set are mixed in, to show the sample holds.

// File: rtl/adcreg_pkg.sv
package adcreg_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int WIX_W       = ADDR_W - 2;
    localparam int N_INJ       = 4;
    localparam int N_SEQ       = 3;
    localparam int STAT_W      = 6;
    localparam int OFF_W       = 12;
    localparam int SAMPLE_W    = 12;
    localparam int SAMPLE_STEP = 7;
    localparam int CTL2_RD_W   = 28;
    localparam int EN_BIT      = 0;
    localparam int ALIGN_BIT   = 11;
    localparam int START_BIT   = 30;
    localparam int RES_LSB     = 24;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [WIX_W-1:0]  wix_t;

    localparam word_t HTR_RST    = 32'h0000_0FFF;
    localparam word_t ALIGN_MASK = 32'h0000_FFF0;

    localparam wix_t IX_STAT  = WIX_W'(0);
    localparam wix_t IX_CTL1  = WIX_W'(1);
    localparam wix_t IX_CTL2  = WIX_W'(2);
    localparam wix_t IX_SMP1  = WIX_W'(3);
    localparam wix_t IX_SMP2  = WIX_W'(4);
    localparam wix_t IX_JOFF0 = WIX_W'(5);
    localparam wix_t IX_HTR   = WIX_W'(5 + N_INJ);
    localparam wix_t IX_LTR   = WIX_W'(6 + N_INJ);
    localparam wix_t IX_SEQ0  = WIX_W'(7 + N_INJ);
    localparam wix_t IX_JSEQ  = WIX_W'(7 + N_INJ + N_SEQ);
    localparam wix_t IX_JDAT0 = WIX_W'(8 + N_INJ + N_SEQ);
    localparam wix_t IX_DATA  = WIX_W'(8 + 2 * N_INJ + N_SEQ);

    typedef struct packed {
        logic [STAT_W-1:0]             status;
        word_t                         ctrl1;
        word_t                         ctrl2;
        word_t                         smp1;
        word_t                         smp2;
        logic [N_INJ-1:0][OFF_W-1:0]   joff;
        word_t                         htr;
        word_t                         ltr;
        logic [N_SEQ-1:0][DATA_W-1:0]  seq;
        word_t                         jseq;
        logic [N_INJ-1:0][DATA_W-1:0]  jdat;
        word_t                         sample;
        word_t                         rdata;
        logic                          rvalid;
    } bank_t;
endpackage

// File: rtl/adcreg_sample_gen.sv
module adcreg_sample_gen
    import adcreg_pkg::*;
(
    input  word_t      cur_sample,
    input  logic [1:0] res_code,
    input  logic       left_align,
    output word_t      next_sample,
    output word_t      fmt_sample
);
    logic [3:0] keep_bits;
    word_t      keep_mask;
    word_t      stepped;

    always_comb begin
        keep_bits   = 4'(SAMPLE_W) - {1'b0, res_code, 1'b0};
        keep_mask   = (word_t'(1) << keep_bits) - word_t'(1);
        stepped     = cur_sample + word_t'(SAMPLE_STEP);
        next_sample = stepped & keep_mask;
        fmt_sample  = left_align ? ((next_sample << 1) & ALIGN_MASK) : next_sample;
    end
endmodule

// File: rtl/adcreg_inj_sub.sv
module adcreg_inj_sub
    import adcreg_pkg::*;
(
    input  logic [N_INJ-1:0][DATA_W-1:0] inj_data,
    input  logic [N_INJ-1:0][OFF_W-1:0]  inj_off,
    output logic [N_INJ-1:0][DATA_W-1:0] inj_diff
);
    for (genvar g = 0; g < N_INJ; g++) begin : g_ch
        assign inj_diff[g] = inj_data[g] - DATA_W'(inj_off[g]);
    end
endmodule

// File: rtl/adcreg_bank.sv
module adcreg_bank
    import adcreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    bank_t q, n;
    wix_t  widx;
    logic  hs, conv_go;
    word_t samp_next, samp_fmt, rd_mux;
    logic [N_INJ-1:0][DATA_W-1:0] inj_diff;
    logic  unused_addr_lsb;

    assign bus_ready       = 1'b1;
    assign hs              = bus_valid & bus_ready;
    assign widx            = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^bus_addr[1:0];
    assign conv_go         = q.ctrl2[EN_BIT] & q.ctrl2[START_BIT];

    adcreg_sample_gen u_gen (
        .cur_sample  (q.sample),
        .res_code    (q.ctrl1[RES_LSB+1:RES_LSB]),
        .left_align  (q.ctrl2[ALIGN_BIT]),
        .next_sample (samp_next),
        .fmt_sample  (samp_fmt)
    );

    adcreg_inj_sub u_inj (
        .inj_data (q.jdat),
        .inj_off  (q.joff),
        .inj_diff (inj_diff)
    );

    always_comb begin
        rd_mux = '0;
        case (widx)
            IX_STAT: rd_mux = DATA_W'(q.status);
            IX_CTL1: rd_mux = q.ctrl1;
            IX_CTL2: rd_mux = DATA_W'(q.ctrl2[CTL2_RD_W-1:0]);
            IX_SMP1: rd_mux = q.smp1;
            IX_SMP2: rd_mux = q.smp2;
            IX_HTR:  rd_mux = q.htr;
            IX_LTR:  rd_mux = q.ltr;
            IX_JSEQ: rd_mux = q.jseq;
            IX_DATA: rd_mux = conv_go ? samp_fmt : '0;
            default: rd_mux = '0;
        endcase
        for (int i = 0; i < N_INJ; i++) begin
            if (widx == IX_JOFF0 + WIX_W'(i)) rd_mux = DATA_W'(q.joff[i]);
            if (widx == IX_JDAT0 + WIX_W'(i)) rd_mux = inj_diff[i];
        end
        for (int i = 0; i < N_SEQ; i++) begin
            if (widx == IX_SEQ0 + WIX_W'(i)) rd_mux = q.seq[i];
        end
    end

    always_comb begin
        n        = q;
        n.rvalid = 1'b0;
        if (hs && bus_write) begin
            case (widx)
                IX_STAT: n.status = q.status & bus_wdata[STAT_W-1:0];
                IX_CTL1: n.ctrl1  = bus_wdata;
                IX_CTL2: n.ctrl2  = bus_wdata;
                IX_SMP1: n.smp1   = bus_wdata;
                IX_SMP2: n.smp2   = bus_wdata;
                IX_HTR:  n.htr    = bus_wdata;
                IX_LTR:  n.ltr    = bus_wdata;
                IX_JSEQ: n.jseq   = bus_wdata;
                default: ;
            endcase
            for (int i = 0; i < N_INJ; i++) begin
                if (widx == IX_JOFF0 + WIX_W'(i)) n.joff[i] = bus_wdata[OFF_W-1:0];
                if (widx == IX_JDAT0 + WIX_W'(i)) n.jdat[i] = bus_wdata;
            end
            for (int i = 0; i < N_SEQ; i++) begin
                if (widx == IX_SEQ0 + WIX_W'(i)) n.seq[i] = bus_wdata;
            end
        end else if (hs) begin
            n.rvalid = 1'b1;
            n.rdata  = rd_mux;
            if (widx == IX_DATA && conv_go) begin
                n.sample           = samp_next;
                n.ctrl2[START_BIT] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.htr <= HTR_RST;
        end else begin
            q <= n;
        end
    end

    assign bus_rdata  = q.rdata;
    assign bus_rvalid = q.rvalid;

    // R11
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);
    // R11
    no_rvalid_otherwise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !bus_rvalid);
    // R2
    status_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && widx == IX_STAT) |=> ((q.status & ~$past(q.status)) == '0));
    // R3
    ctrl2_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && widx == IX_CTL2) |=> (bus_rdata[DATA_W-1:CTL2_RD_W] == '0));
    // R6
    start_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && widx == IX_DATA && conv_go) |=> !q.ctrl2[START_BIT]);
    // R9
    idle_sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && widx == IX_DATA && !conv_go) |=> $stable(q.sample));
    // R7
    sample_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sample[DATA_W-1:SAMPLE_W] == '0);
endmodule

// File: tb/adcreg_bank_tb.sv
module adcreg_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int errs = 0;
    int checks = 0;
    logic [31:0] model = '0;

    adcreg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        chk("R11 ready high", {31'b0, bus_ready}, 32'd1);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        chk("R11 no rvalid after write", {31'b0, bus_rvalid}, 32'd0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        chk("R11 rvalid idle", {31'b0, bus_rvalid}, 32'd0);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R11 rvalid after read", {31'b0, bus_rvalid}, 32'd1);
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    function automatic logic [31:0] res_mask(input int res);
        return (32'd1 << (12 - 2 * res)) - 32'd1;
    endfunction

    task automatic t_reset();
        for (int i = 0; i < 22; i++) begin
            rd_chk("R1 reset value", 8'(i * 4), (i == 9) ? 32'h0000_0FFF : 32'h0);
        end
    endtask

    task automatic t_status();
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 status not settable", 8'h00, 32'h0);
    endtask

    task automatic t_plain();
        logic [7:0] addrs [10] = '{8'h04, 8'h0C, 8'h10, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C};
        for (int i = 0; i < 10; i++) wr(addrs[i], 32'hC35A_0000 ^ (32'h1111_0101 * (i + 1)));
        for (int i = 0; i < 10; i++) rd_chk("R12 readback", addrs[i], 32'hC35A_0000 ^ (32'h1111_0101 * (i + 1)));
        wr(8'h04, 32'h0);
        wr(8'h3C, 32'h0);
    endtask

    task automatic t_ctrl2();
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk("R3 ctrl2 top nibble", 8'h08, 32'h0FFF_FFFF);
        wr(8'h08, 32'hA000_0801);
        rd_chk("R3 ctrl2 partial", 8'h08, 32'h0000_0801);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_inj();
        for (int i = 0; i < 4; i++) begin
            wr(8'(8'h14 + 4 * i), 32'hFFFF_F000 | (32'h0F0 * (i + 1)));
            wr(8'(8'h3C + 4 * i), 32'h10 + 32'h200 * i);
        end
        for (int i = 0; i < 4; i++) begin
            rd_chk("R4 offset 12 bits", 8'(8'h14 + 4 * i), 32'h0F0 * (i + 1));
            rd_chk("R5 injected diff", 8'(8'h3C + 4 * i), (32'h10 + 32'h200 * i) - (32'h0F0 * (i + 1)));
        end
    endtask

    task automatic t_idle();
        wr(8'h08, 32'h0000_0001);
        rd_chk("R9 enable only", 8'h4C, 32'h0);
        wr(8'h08, 32'h4000_0000);
        rd_chk("R9 start only", 8'h4C, 32'h0);
        wr(8'h08, 32'h0);
    endtask

    task automatic conv(input int res, input bit align);
        wr(8'h04, 32'(res) << 24);
        wr(8'h08, 32'h4000_0001 | (align ? 32'h800 : 32'h0));
        model = (model + 32'd7) & res_mask(res);
        rd_chk(align ? "R8 aligned sample" : "R6 R7 sample", 8'h4C,
               align ? ((model << 1) & 32'hFFF0) : model);
        rd_chk("R6 start cleared", 8'h4C, 32'h0);
    endtask

    task automatic t_sample();
        for (int k = 0; k < 6; k++) conv(0, 1'b0);
        for (int r = 1; r < 4; r++) begin
            for (int k = 0; k < 40; k++) conv(r, 1'b0);
        end
        t_idle();
    endtask

    task automatic t_align();
        for (int k = 0; k < 5; k++) conv(0, 1'b1);
        for (int k = 0; k < 12; k++) conv(3, 1'b1);
    endtask

    task automatic t_undec();
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'hFC, 32'h1234_5678);
        rd_chk("R10 undecoded read", 8'h50, 32'h0);
        rd_chk("R10 undecoded read top", 8'hFC, 32'h0);
        rd_chk("R10 neighbour untouched", 8'h24, 32'hC35A_0000 ^ (32'h1111_0101 * 4));
        wr(8'h4C, 32'h0000_0ABC);
        conv(0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_status();
        t_plain();
        t_ctrl2();
        t_inj();
        t_idle();
        t_sample();
        t_align();
        t_undec();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule